// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Threshold Flags and Byte Parity

The block moves 36-bit words from a write port to a read port, each port on its own free-running clock. The two clocks may be unrelated or the same net. The store holds 64 words. Each side has its own status flags. The write side shows full and almost-full. The read side shows empty and almost-empty. The almost-flag thresholds come from two level inputs.

Each side works out its flags from its own pointer and a copy of the other side's pointer. That copy crosses the clock boundary in Gray code through a two-stage synchronizer, so flags on each side lag the far side's activity by a few cycles.

A word is four 9-bit bytes. Each byte has 8 data bits and one odd-parity bit. Both ports check parity without taking part in the data path and report a mismatch on their own error output. A mode input can make the read port output freshly computed parity bits in place of the stored ones.

Top module: `xdom_word_fifo`

## Requirements
- R1: While `rst_n` is low, and after its release, the flags are empty=1, almost_empty=1, full=0 and almost_full=0. `r_data` holds the word with every parity bit set and every data bit clear, and both parity-error outputs are 0.
- R2: Words leave in the order they were written. The accepted word appears on `r_data` right after the `rclk` rising edge on which `r_en` was sampled high with `empty` low.
- R3: `full` rises on the `wclk` edge that stores the 64th word. A write presented while `full` is high stores nothing and moves no pointer.
- R4: `empty` is high when no word is held. A read presented while `empty` is high moves no pointer and leaves `r_data` unchanged.
- R5: With the two clocks tied together, `empty` falls on the third edge after the write edge that ends an empty state. `full` falls on the third edge after the read edge that frees a slot.
- R6: `almost_full` is high when the free slots (64 minus stored words) are at or below `af_level`, which ranges from 0 to 63.
- R7: `almost_empty` is high when the stored word count is at or below `ae_level`, which ranges from 0 to 63.
- R8: `w_parity_err` is high while `w_en` is high and any byte of `w_data` fails odd parity. Byte i spans bits 9i+8..9i, with the parity bit at 9i+8 and the data at 9i+7..9i. A byte passes when its 9 bits hold an odd number of ones.
- R9: A word with a parity error is stored and read back unchanged. Parity never blocks a transfer.
- R10: `r_parity_err` is high when any byte of the stored output word fails odd parity. It uses the R8 byte layout and looks at the word as stored, before any parity regeneration.
- R11: While `gen_parity` is 1, each parity bit 9i+8 of `r_data` is the odd parity of data bits 9i+7..9i, and every data bit is unchanged. While `gen_parity` is 0, `r_data` is the stored word.
- R12: A write and a read on the same edge, with neither full nor empty, both take effect. The stored count stays the same and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wclk | input | 1 | Write-port clock |
| w_en | input | 1 | Write request |
| w_data | input | 36 | Word to store |
| af_level | input | 6 | Almost-full threshold in free slots |
| full | output | 1 | No free slot (write domain) |
| almost_full | output | 1 | Free slots at or below threshold (write domain) |
| w_parity_err | output | 1 | Write word fails byte parity |
| rclk | input | 1 | Read-port clock |
| r_en | input | 1 | Read request |
| gen_parity | input | 1 | Replace output parity bits with computed ones |
| ae_level | input | 6 | Almost-empty threshold in stored words |
| r_data | output | 36 | Output word register |
| empty | output | 1 | No word held (read domain) |
| almost_empty | output | 1 | Stored words at or below threshold (read domain) |
| r_parity_err | output | 1 | Stored output word fails byte parity |

## Verification
The bench builds the block with its default parameters: 36-bit words, a 6-bit address and two synchronizer stages. Both port clocks are driven from one 250 MHz source. That fixes the synchronizer latency to an exact number of edges, so the R5 flag delays can be checked on the cycle. With 64 slots, filling to full, crossing both thresholds and wrapping the pointers past the top of the store all take only a few hundred cycles.

// File: rtl/xf_pkg.sv
`timescale 1ns/1ps
package xf_pkg;
    localparam int LANE_W = 9;

    // odd-parity bit for one lane of 8 data bits
    function automatic logic lane_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    // a 9-bit lane fails when its ones count is even
    function automatic logic lane_bad(input logic [LANE_W-1:0] lane);
        return ~(^lane);
    endfunction
endpackage

// File: rtl/xf_rst_sync.sv
`timescale 1ns/1ps
module xf_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [1:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[0], 1'b1};

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign srst_n = sh_q[1];
endmodule

// File: rtl/xf_gray_sync.sv
`timescale 1ns/1ps
module xf_gray_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2   // at least 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = W * STAGES;
    logic [CW-1:0] chain_q, chain_d;

    always_comb chain_d = {chain_q[CW-W-1:0], d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/xf_par_unit.sv
`timescale 1ns/1ps
module xf_par_unit #(
    parameter int DATA_W = 36   // a multiple of the 9-bit lane
) (
    input  logic [DATA_W-1:0] word,
    input  logic              regen,
    output logic              err,
    output logic [DATA_W-1:0] word_out
);
    import xf_pkg::*;
    localparam int NL = DATA_W / LANE_W;
    logic [NL-1:0] bad;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign bad[l] = lane_bad(word[LANE_W*l +: LANE_W]);
        assign word_out[LANE_W*l +: LANE_W] = regen
            ? {lane_par(word[LANE_W*l +: 8]), word[LANE_W*l +: 8]}
            : word[LANE_W*l +: LANE_W];
    end

    assign err = |bad;
endmodule

// File: rtl/xf_mem.sv
`timescale 1ns/1ps
module xf_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/xf_wr_side.sv
`timescale 1ns/1ps
module xf_wr_side #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_en,
    input  logic [ADDR_W-1:0] af_level,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic              full,
    output logic              almost_full
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
    } wst_t;

    wst_t s_q, s_d;
    logic [PW-1:0] rbin_s, bin_nx, used_nx, free_nx;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rbin_s   = g2b(rgray_sync);
        we       = w_en && !s_q.full;
        bin_nx   = s_q.bin + PW'(we);
        used_nx  = bin_nx - rbin_s;
        free_nx  = DEPTH - used_nx;
        s_d.bin  = bin_nx;
        s_d.gray = bin_nx ^ (bin_nx >> 1);
        s_d.full = (used_nx == DEPTH);
        s_d.afull = (free_nx <= {1'b0, af_level});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wgray       = s_q.gray;
    assign waddr       = s_q.bin[ADDR_W-1:0];
    assign full        = s_q.full;
    assign almost_full = s_q.afull;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bin - rbin_s) <= DEPTH);
    // R3
    full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && w_en && (rbin_s == $past(rbin_s))) |=> $stable(s_q.bin));
    // R6
    full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> s_q.afull);
    // R5
    wgray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.gray ^ $past(s_q.gray)));
endmodule

// File: rtl/xf_rd_side.sv
`timescale 1ns/1ps
module xf_rd_side #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] ae_level,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] word,
    output logic              empty,
    output logic              almost_empty
);
    import xf_pkg::*;
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;
    localparam int NL = DATA_W / LANE_W;

    function automatic logic [DATA_W-1:0] idle_word();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int l = 0; l < NL; l++) w[LANE_W*l + 8] = 1'b1;
        return w;
    endfunction
    localparam logic [DATA_W-1:0] IDLE_WORD = idle_word();

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic              empty;
        logic              aempty;
        logic [DATA_W-1:0] data;
    } rst_t;

    rst_t s_q, s_d;
    logic          re;
    logic [PW-1:0] wbin_s, bin_nx, used_nx;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin_s     = g2b(wgray_sync);
        re         = r_en && !s_q.empty;
        bin_nx     = s_q.bin + PW'(re);
        used_nx    = wbin_s - bin_nx;
        s_d.bin    = bin_nx;
        s_d.gray   = bin_nx ^ (bin_nx >> 1);
        s_d.empty  = (used_nx == '0);
        s_d.aempty = (used_nx <= {1'b0, ae_level});
        s_d.data   = re ? mem_rdata : s_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1, data: IDLE_WORD};
        else        s_q <= s_d;
    end

    assign rgray        = s_q.gray;
    assign raddr        = s_q.bin[ADDR_W-1:0];
    assign word         = s_q.data;
    assign empty        = s_q.empty;
    assign almost_empty = s_q.aempty;

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_s - s_q.bin) <= DEPTH);
    // R4
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && s_q.empty) |=> $stable(s_q.data));
    // R7
    empty_implies_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.empty |-> s_q.aempty);
    // R5
    rgray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.gray ^ $past(s_q.gray)));
endmodule

// File: rtl/xdom_word_fifo.sv
`timescale 1ns/1ps
module xdom_word_fifo #(
    parameter int DATA_W      = 36,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              wclk,
    input  logic              w_en,
    input  logic [DATA_W-1:0] w_data,
    input  logic [ADDR_W-1:0] af_level,
    output logic              full,
    output logic              almost_full,
    output logic              w_parity_err,
    input  logic              rclk,
    input  logic              r_en,
    input  logic              gen_parity,
    input  logic [ADDR_W-1:0] ae_level,
    output logic [DATA_W-1:0] r_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              r_parity_err
);
    localparam int PW = ADDR_W + 1;

    logic              wrst_n, rrst_n, we, w_err_raw;
    logic [PW-1:0]     wgray, rgray, wgray_in_r, rgray_in_w;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rdata, held_word, w_fixed_unused;

    xf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
    xf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

    xf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_in_w));
    xf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_in_r));

    xf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .w_en(w_en), .af_level(af_level),
        .rgray_sync(rgray_in_w), .wgray(wgray), .waddr(waddr), .we(we),
        .full(full), .almost_full(almost_full));

    xf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(w_data),
        .raddr(raddr), .rdata(mem_rdata));

    xf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .r_en(r_en), .ae_level(ae_level),
        .wgray_sync(wgray_in_r), .mem_rdata(mem_rdata), .rgray(rgray),
        .raddr(raddr), .word(held_word), .empty(empty),
        .almost_empty(almost_empty));

    xf_par_unit #(.DATA_W(DATA_W)) u_wpar (
        .word(w_data), .regen(1'b0), .err(w_err_raw), .word_out(w_fixed_unused));
    xf_par_unit #(.DATA_W(DATA_W)) u_rpar (
        .word(held_word), .regen(gen_parity), .err(r_parity_err), .word_out(r_data));

    assign w_parity_err = w_en && w_err_raw;

    // R9
    store_despite_parity_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_en && !full && w_parity_err) |-> we);
endmodule

// File: tb/sim_xdom_word_fifo.sv
`timescale 1ns/1ps
module sim_xdom_word_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        w_en = 1'b0, r_en = 1'b0, gen_parity = 1'b0;
    logic [35:0] w_data = '0;
    logic [5:0]  af_level = 6'd4, ae_level = 6'd4;
    logic        full, almost_full, w_parity_err, empty, almost_empty, r_parity_err;
    logic [35:0] r_data;

    int nchk = 0, nfail = 0, seed = 1;
    bit done = 1'b0;
    logic [35:0] mq [$];

    always #2 clk = ~clk;

    xdom_word_fifo u0 (
        .rst_n(rst_n), .wclk(clk), .w_en(w_en), .w_data(w_data), .af_level(af_level),
        .full(full), .almost_full(almost_full), .w_parity_err(w_parity_err),
        .rclk(clk), .r_en(r_en), .gen_parity(gen_parity), .ae_level(ae_level),
        .r_data(r_data), .empty(empty), .almost_empty(almost_empty),
        .r_parity_err(r_parity_err));

    typedef struct packed {
        int   nwr;
        int   nrd;
        logic f;
        logic af;
        logic e;
        logic ae;
    } vec_t;

    // thresholds 4/4; running stored count after each row in the comment
    localparam vec_t TBL [12] = '{
        '{3, 0, 1'b0, 1'b0, 1'b0, 1'b1},   // 3
        '{2, 0, 1'b0, 1'b0, 1'b0, 1'b0},   // 5
        '{55, 0, 1'b0, 1'b1, 1'b0, 1'b0},  // 60
        '{3, 0, 1'b0, 1'b1, 1'b0, 1'b0},   // 63
        '{1, 0, 1'b1, 1'b1, 1'b0, 1'b0},   // 64
        '{2, 0, 1'b1, 1'b1, 1'b0, 1'b0},   // 64, writes dropped
        '{0, 1, 1'b0, 1'b1, 1'b0, 1'b0},   // 63
        '{0, 60, 1'b0, 1'b0, 1'b0, 1'b1},  // 3
        '{0, 3, 1'b0, 1'b0, 1'b1, 1'b1},   // 0
        '{0, 2, 1'b0, 1'b0, 1'b1, 1'b1},   // 0, reads dropped
        '{40, 20, 1'b0, 1'b0, 1'b0, 1'b0}, // 20, pointers wrap
        '{0, 20, 1'b0, 1'b0, 1'b1, 1'b1}   // 0
    };

    localparam logic [35:0] IDLE = 36'h800000000 | 36'h004000000 | 36'h000020000 | 36'h000000100;

    function automatic logic [35:0] mk_word(input int s);
        logic [35:0] w;
        for (int l = 0; l < 4; l++) begin
            logic [7:0] d;
            d = 8'((s * 37) + (l * 91) + (s >> 3));
            w[9*l +: 9] = {~(^d), d};
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    task automatic write_word(input logic [35:0] d, output logic perr);
        logic acc;
        acc = !full;
        w_data = d;
        w_en = 1'b1;
        #1 perr = w_parity_err;
        @(posedge clk);
        @(negedge clk);
        w_en = 1'b0;
        if (acc) mq.push_back(d);
    endtask

    task automatic read_word();
        logic acc;
        logic [35:0] prev, exp;
        acc = !empty;
        prev = r_data;
        r_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        r_en = 1'b0;
        if (acc) begin
            exp = mq.pop_front();
            check(r_data == exp, "R2", r_data, exp);
        end else begin
            check(r_data == prev, "R4", r_data, prev);
        end
    endtask

    task automatic both_ops(input logic [35:0] d);
        logic wacc, racc;
        logic [35:0] exp;
        wacc = !full;
        racc = !empty;
        w_data = d;
        w_en = 1'b1;
        r_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        w_en = 1'b0;
        r_en = 1'b0;
        if (racc) begin
            exp = mq.pop_front();
            check(r_data == exp, "R12", r_data, exp);
        end
        if (wacc) mq.push_back(d);
    endtask

    task automatic check_flags(input logic f, input logic af, input logic e, input logic ae, input string tag);
        check(full == f, {tag, " R3 full"}, 36'(full), 36'(f));
        check(almost_full == af, {tag, " R6 almost_full"}, 36'(almost_full), 36'(af));
        check(empty == e, {tag, " R4 empty"}, 36'(empty), 36'(e));
        check(almost_empty == ae, {tag, " R7 almost_empty"}, 36'(almost_empty), 36'(ae));
    endtask

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic pe;
        logic [35:0] bad, fixed;

        repeat (4) @(negedge clk);
        // R1: state while reset is held
        check_flags(1'b0, 1'b0, 1'b1, 1'b1, "R1 in-reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_flags(1'b0, 1'b0, 1'b1, 1'b1, "R1");
        check(r_data == IDLE, "R1 r_data", r_data, IDLE);
        check(r_parity_err == 1'b0, "R1 r_parity_err", 36'(r_parity_err), 36'd0);

        // vector table walk
        foreach (TBL[i]) begin
            for (int k = 0; k < TBL[i].nwr; k++) begin
                write_word(mk_word(seed), pe);
                seed++;
                check(pe == 1'b0, "R8 good word", 36'(pe), 36'd0);
            end
            for (int k = 0; k < TBL[i].nrd; k++) read_word();
            repeat (5) @(negedge clk);
            check_flags(TBL[i].f, TBL[i].af, TBL[i].e, TBL[i].ae, $sformatf("row%0d", i));
        end

        // R5 / R7: empty and almost_empty fall on the third edge
        ae_level = 6'd0;
        af_level = 6'd0;
        repeat (5) @(negedge clk);
        check(almost_empty == 1'b1, "R7 level0 empty", 36'(almost_empty), 36'd1);
        write_word(mk_word(seed), pe);
        seed++;
        check(empty == 1'b1, "R5 edge1", 36'(empty), 36'd1);
        @(negedge clk);
        check(empty == 1'b1, "R5 edge2", 36'(empty), 36'd1);
        @(negedge clk);
        check(empty == 1'b1, "R5 edge3-pre", 36'(empty), 36'd1);
        @(negedge clk);
        check(empty == 1'b0, "R5 edge3", 36'(empty), 36'd0);
        check(almost_empty == 1'b0, "R7 level0 one word", 36'(almost_empty), 36'd0);

        // R3 / R6: fill, full rises on the 64th write edge
        for (int k = 0; k < 62; k++) begin
            write_word(mk_word(seed), pe);
            seed++;
        end
        check(full == 1'b0, "R3 at 63", 36'(full), 36'd0);
        check(almost_full == 1'b0, "R6 level0 at 63", 36'(almost_full), 36'd0);
        write_word(mk_word(seed), pe);
        seed++;
        check(full == 1'b1, "R3 at 64", 36'(full), 36'd1);
        check(almost_full == 1'b1, "R6 level0 at 64", 36'(almost_full), 36'd1);

        // R5: full falls on the third edge after a read
        read_word();
        check(full == 1'b1, "R5 full edge1", 36'(full), 36'd1);
        @(negedge clk);
        check(full == 1'b1, "R5 full edge2", 36'(full), 36'd1);
        @(negedge clk);
        check(full == 1'b1, "R5 full edge3-pre", 36'(full), 36'd1);
        @(negedge clk);
        check(full == 1'b0, "R5 full edge3", 36'(full), 36'd0);
        for (int k = 0; k < 63; k++) read_word();
        ae_level = 6'd4;
        af_level = 6'd4;
        repeat (5) @(negedge clk);
        check_flags(1'b0, 1'b0, 1'b1, 1'b1, "drained");

        // R8 / R9 / R10 / R11: parity lane 2 flipped
        bad = mk_word(500) ^ 36'h4000000;
        fixed = mk_word(500);
        write_word(bad, pe);
        check(pe == 1'b1, "R8 bad word", 36'(pe), 36'd1);
        repeat (5) @(negedge clk);
        read_word();
        check(r_data == bad, "R9 stored as written", r_data, bad);
        check(r_parity_err == 1'b1, "R10 bad held word", 36'(r_parity_err), 36'd1);
        gen_parity = 1'b1;
        #1;
        check(r_data == fixed, "R11 regenerated", r_data, fixed);
        check(r_parity_err == 1'b1, "R10 stored word still bad", 36'(r_parity_err), 36'd1);
        @(negedge clk);
        gen_parity = 1'b0;
        #1;
        check(r_data == bad, "R11 off", r_data, bad);
        @(negedge clk);

        // R12: simultaneous write and read
        for (int k = 0; k < 10; k++) begin
            write_word(mk_word(seed), pe);
            seed++;
        end
        repeat (5) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            both_ops(mk_word(seed));
            seed++;
        end
        repeat (5) @(negedge clk);
        check(36'(mq.size()) == 36'd10, "R12 count kept", 36'(mq.size()), 36'd10);
        check_flags(1'b0, 1'b0, 1'b0, 1'b0, "R12");
        for (int k = 0; k < 10; k++) read_word();

        // R1: reset with data inside
        for (int k = 0; k < 5; k++) begin
            write_word(mk_word(seed), pe);
            seed++;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        repeat (4) @(negedge clk);
        check_flags(1'b0, 1'b0, 1'b1, 1'b1, "R1 re-reset");
        check(r_data == IDLE, "R1 r_data re-reset", r_data, IDLE);

        report();
    end
endmodule